// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block connects a CPU-side memory-mapped port to a PCI configuration access port. The CPU side sees two windows of 4 KB each, selected by the top bit of the access address. The lower window holds a 32-bit stored configuration address. An access in the upper window is turned into one request on the configuration port. The block builds the outgoing address from the stored value and the low bits of the data-window offset.

The stored value is read in one of three formats. Bit 31 set means override: the value goes out almost as stored. Bit 31 clear with bit 0 set means type-1 pass-through. With both bits clear, the value holds a one-hot device select in bits 31:11, and the block converts it into a binary device number. The CPU is held until the configuration port acknowledges, and read data comes back unchanged. An empty one-hot field ends the access at once, as a master abort.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the stored address reads as zero, and both `ready_o` and `cfg_req_o` are low.
- R2: A write to the address window (`addr_i[12]`=0) updates the stored address one byte lane at a time: `be_i[k]` enables bits 8k+7..8k. A read of the address window returns the stored value.
- R3: If stored bit 31 is set, a data-window access (`addr_i[12]`=1) sends out the stored value ORed with offset bits 1:0.
- R4: If stored bit 31 is clear and bit 0 is set, the outgoing address is stored bits 31:3 followed by offset bits 2:0.
- R5: If stored bits 31 and 0 are both clear, outgoing bits 15:11 carry the device number. This is the index of the lowest set stored bit in 31:11, counted from bit 11 as zero.
- R6: In that one-hot format, outgoing bits 10:8 are stored bits 10:8 (function) and bits 7:3 are stored bits 7:3 (register). Bits 2:0 are offset bits 2:0, and bits 31:16 are zero.
- R7: In the one-hot format with stored bits 31:11 all zero, no configuration request is issued. A read returns 0xFFFFFFFF, a write is dropped, and `ready_o` pulses on the cycle after acceptance.
- R8: The access size (`size_i`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and the write data pass to the configuration port unchanged. Configuration read data is returned unchanged on `rdata_o`.
- R9: Each forwarded access raises `cfg_req_o` for exactly one cycle. `ready_o` pulses for one cycle, one cycle after the clock edge that samples `cfg_ack_i`. An address-window access completes with `ready_o` on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request, held until `ready_o` |
| we_i | input | 1 | CPU write when high |
| addr_i | input | 13 | Bit 12 selects the window, bits 11:0 are the offset |
| wdata_i | input | 32 | CPU write data, little-endian lanes |
| be_i | input | 4 | Byte enables for address-window writes |
| size_i | input | 2 | Data-window access size code |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with `ready_o` |
| cfg_req_o | output | 1 | One-cycle configuration request |
| cfg_we_o | output | 1 | Configuration write when high |
| cfg_addr_o | output | 32 | Converted configuration address |
| cfg_size_o | output | 2 | Forwarded size code |
| cfg_wdata_o | output | 32 | Forwarded write data |
| cfg_ack_i | input | 1 | Configuration access done |
| cfg_rdata_i | input | 32 | Configuration read data |

## Verification
The stored value is set to patterns that pick each format. These are the override bit alone and together with bit 0, a type-1 value, and one-hot values with a single bit at the bottom, middle and top of the field. Several bits are also set at once, so the lowest-bit rule can be told apart from a highest-bit or OR-based encoder. An empty field separates the abort path from a request with device number zero. Each offset and size is compared at the configuration port, and the acknowledge delays of zero, three and seven cycles show whether completion tracks the acknowledge or a fixed count.

// File: rtl/cfg_xlate_pkg.sv
`timescale 1ns/1ps
package cfg_xlate_pkg;
  typedef enum logic [1:0] {FMT_OVR = 2'd0, FMT_TYPE1 = 2'd1, FMT_IDSEL = 2'd2} cfg_fmt_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_RESP = 2'd2} xl_state_e;
endpackage

// File: rtl/cfg_addr_store.sv
`timescale 1ns/1ps
module cfg_addr_store #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               q_o[8*b +: 8] <= '0;
      else if (wr_i && be_i[b])  q_o[8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/cfg_addr_conv.sv
`timescale 1ns/1ps
module cfg_addr_conv
  import cfg_xlate_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEV_LO = 11,
  parameter int OFF_W  = 3,
  localparam int DEVW  = $clog2(DW - DEV_LO)
) (
  input  logic [DW-1:0]    stored_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [DW-1:0]    addr_o,
  output logic             abort_o,
  output cfg_fmt_e         fmt_o
);
  logic [DEVW-1:0] dev;
  logic            hit;

  // descending scan: the last match is the lowest set bit
  always_comb begin
    dev = '0;
    hit = 1'b0;
    for (int i = DW - 1; i >= DEV_LO; i--) begin
      if (stored_i[i]) begin
        dev = DEVW'(i - DEV_LO);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (stored_i[DW-1])   fmt_o = FMT_OVR;
    else if (stored_i[0]) fmt_o = FMT_TYPE1;
    else                  fmt_o = FMT_IDSEL;
  end

  always_comb begin
    addr_o = '0;
    unique case (fmt_o)
      FMT_OVR:   addr_o = stored_i | DW'(off_i[1:0]);
      FMT_TYPE1: addr_o = {stored_i[DW-1:OFF_W], off_i};
      default: begin
        addr_o[DEV_LO +: DEVW] = dev;
        addr_o[DEV_LO-1:OFF_W] = stored_i[DEV_LO-1:OFF_W];
        addr_o[OFF_W-1:0]      = off_i;
      end
    endcase
  end

  assign abort_o = (fmt_o == FMT_IDSEL) && !hit;
endmodule

// File: rtl/cfg_access_ctl.sv
`timescale 1ns/1ps
module cfg_access_ctl
  import cfg_xlate_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          win_data_i,
  input  logic          abort_i,
  input  logic [DW-1:0] conv_addr_i,
  input  logic [DW-1:0] stored_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    size_i,
  output logic          addr_wr_o,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [DW-1:0] cfg_addr_o,
  output logic [1:0]    cfg_size_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ack_i,
  input  logic [DW-1:0] cfg_rdata_i
);
  xl_state_e state_q;

  assign addr_wr_o = (state_q == ST_IDLE) && req_i && !win_data_i && we_i;
  assign ready_o   = (state_q == ST_RESP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_o     <= '0;
      cfg_req_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_addr_o  <= '0;
      cfg_size_o  <= '0;
      cfg_wdata_o <= '0;
    end else begin
      cfg_req_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (!win_data_i) begin
            rdata_o <= stored_i;
            state_q <= ST_RESP;
          end else if (abort_i) begin
            rdata_o <= '1;
            state_q <= ST_RESP;
          end else begin
            cfg_req_o   <= 1'b1;
            cfg_we_o    <= we_i;
            cfg_addr_o  <= conv_addr_i;
            cfg_size_o  <= size_i;
            cfg_wdata_o <= wdata_i;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: if (cfg_ack_i) begin
          rdata_o <= cfg_rdata_i;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_addr_xlate.sv
`timescale 1ns/1ps
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WIN_W  = 12,
  parameter int DEV_LO = 11,
  localparam int NB    = DW / 8,
  localparam int OFF_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [WIN_W:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic [1:0]    size_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [DW-1:0] cfg_addr_o,
  output logic [1:0]    cfg_size_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ack_i,
  input  logic [DW-1:0] cfg_rdata_i
);
  logic [DW-1:0] addr_q;
  logic [DW-1:0] conv_addr;
  logic          addr_wr;
  logic          abort;
  cfg_fmt_e      fmt;

  cfg_addr_store #(.DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (addr_wr),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .q_o     (addr_q)
  );

  cfg_addr_conv #(.DW(DW), .DEV_LO(DEV_LO), .OFF_W(OFF_W)) u_conv (
    .stored_i (addr_q),
    .off_i    (addr_i[OFF_W-1:0]),
    .addr_o   (conv_addr),
    .abort_o  (abort),
    .fmt_o    (fmt)
  );

  cfg_access_ctl #(.DW(DW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .win_data_i  (addr_i[WIN_W]),
    .abort_i     (abort),
    .conv_addr_i (conv_addr),
    .stored_i    (addr_q),
    .wdata_i     (wdata_i),
    .size_i      (size_i),
    .addr_wr_o   (addr_wr),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .cfg_req_o   (cfg_req_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_size_o  (cfg_size_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_ack_i   (cfg_ack_i),
    .cfg_rdata_i (cfg_rdata_i)
  );
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
`timescale 1ns/1ps
module cfg_addr_xlate_chk #(
  parameter int DW     = 32,
  parameter int DEV_LO = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] stored_i,
  input logic          ready_o,
  input logic          cfg_req_o,
  input logic [DW-1:0] cfg_addr_o,
  input logic [1:0]    cfg_size_o
);
  logic idsel;
  assign idsel = !stored_i[DW-1] && !stored_i[0];

  p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);
  p_ready_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_ready_not_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cfg_req_o);
  p_size_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> cfg_size_o != 2'd3);
  p_ovr_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && stored_i[DW-1] |-> cfg_addr_o[DW-1:2] == stored_i[DW-1:2]);
  p_type1_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !stored_i[DW-1] && stored_i[0] |-> cfg_addr_o[DW-1:3] == stored_i[DW-1:3]);
  p_dev_bit_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && idsel |-> stored_i[DEV_LO + int'(cfg_addr_o[DEV_LO +: 5])]);
  p_idsel_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && idsel |-> cfg_addr_o[DW-1:16] == '0 && cfg_addr_o[10:3] == stored_i[10:3]);
  p_no_req_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> !(idsel && stored_i[DW-1:DEV_LO] == '0));
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(.DW(DW), .DEV_LO(DEV_LO)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stored_i   (addr_q),
  .ready_o    (ready_o),
  .cfg_req_o  (cfg_req_o),
  .cfg_addr_o (cfg_addr_o),
  .cfg_size_o (cfg_size_o)
);

// File: tb/cfg_addr_xlate_test.sv
`timescale 1ns/1ps
module cfg_addr_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [1:0]  size = '0;
  logic        ready_o, cfg_req_o, cfg_we_o;
  logic [31:0] rdata_o, cfg_addr_o, cfg_wdata_o;
  logic [1:0]  cfg_size_o;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  always #10 clk = ~clk;

  cfg_addr_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .size_i(size), .ready_o(ready_o), .rdata_o(rdata_o),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
    .cfg_size_o(cfg_size_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata)
  );

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic        we;
    logic [1:0]  sz;
    logic [31:0] wd;
  } item_t;

  item_t       exp_q[$];
  int          total = 0, fails = 0;
  int          resp_delay = 0;
  logic [31:0] cur = '0;
  bit          done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return a ^ 32'h5A00_00C3;
  endfunction

  function automatic bit model_abort(input logic [31:0] s);
    return !s[31] && !s[0] && (s[31:11] == '0);
  endfunction

  function automatic logic [31:0] model_addr(input logic [31:0] s, input logic [2:0] off);
    logic [31:0] r;
    int dev;
    if (s[31]) return s | {30'd0, off[1:0]};
    if (s[0])  return {s[31:3], off};
    dev = 0;
    for (int i = 31; i >= 11; i--) if (s[i]) dev = i - 11;
    r = '0;
    r[15:11] = dev[4:0];
    r[10:3]  = s[10:3];
    r[2:0]   = off;
    return r;
  endfunction

  // monitor: compares each request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cfg_req_o) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R7/R9: actual unexpected request addr %h expected none", cfg_addr_o);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk({e.tag, " addr"}, cfg_addr_o, e.addr);
        chk("R8 we", {31'd0, cfg_we_o}, {31'd0, e.we});
        chk("R8 size", {30'd0, cfg_size_o}, {30'd0, e.sz});
        if (e.we) chk("R8 wdata", cfg_wdata_o, e.wd);
      end
    end
  end

  // configuration port responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cfg_req_o) begin
        logic [31:0] a;
        a = cfg_addr_o;
        repeat (resp_delay) @(negedge clk);
        cfg_ack   = 1'b1;
        cfg_rdata = model_rd(a);
        @(negedge clk);
        cfg_ack   = 1'b0;
      end
    end
  end

  task automatic cpu_acc(input bit dwin, input logic [11:0] off, input bit w,
                         input logic [31:0] wd, input logic [3:0] b, input logic [1:0] sz,
                         output logic [31:0] rd, output int waits);
    @(negedge clk);
    req = 1'b1; we = w; addr = {dwin, off}; wdata = wd; be = b; size = sz;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!ready_o && waits < 100);
    rd = rdata_o;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] v, input logic [3:0] b);
    logic [31:0] rd;
    int w;
    cpu_acc(1'b0, 12'h000, 1'b1, v, b, 2'd2, rd, w);
    for (int k = 0; k < 4; k++) if (b[k]) cur[8*k +: 8] = v[8*k +: 8];
    chk("R9 addr write latency", w, 1);
  endtask

  task automatic data_acc(input string tag, input logic [11:0] off, input bit w,
                          input logic [31:0] wd, input logic [1:0] sz, input int d);
    logic [31:0] rd, ea;
    int waits;
    item_t it;
    resp_delay = d;
    ea = model_addr(cur, off[2:0]);
    if (model_abort(cur)) begin
      cpu_acc(1'b1, off, w, wd, 4'hF, sz, rd, waits);
      chk({tag, " abort latency"}, waits, 1);
      if (!w) chk({tag, " abort read"}, rd, 32'hFFFF_FFFF);
    end else begin
      it.tag = tag; it.addr = ea; it.we = w; it.sz = sz; it.wd = wd;
      exp_q.push_back(it);
      cpu_acc(1'b1, off, w, wd, 4'hF, sz, rd, waits);
      chk("R9 completion after ack", waits, d + 2);
      if (!w) chk("R8 read data", rd, model_rd(ea));
    end
    repeat (2) @(negedge clk);
    chk({tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    repeat (3) @(negedge clk);
    chk("R1 ready low", {31'd0, ready_o}, 32'd0);
    chk("R1 req low", {31'd0, cfg_req_o}, 32'd0);
    rst_n = 1'b1;
    cpu_acc(1'b0, 12'h000, 1'b0, '0, 4'hF, 2'd2, rd, w);
    chk("R1 stored zero", rd, 32'd0);

    // R2 byte-lane writes
    set_addr(32'h1234_5678, 4'hF);
    cpu_acc(1'b0, 12'h004, 1'b0, '0, 4'hF, 2'd2, rd, w);
    chk("R2 readback", rd, 32'h1234_5678);
    set_addr(32'hAABB_CCDD, 4'b0010);
    cpu_acc(1'b0, 12'h000, 1'b0, '0, 4'hF, 2'd2, rd, w);
    chk("R2 lane1", rd, 32'h1234_CC78);
    set_addr(32'h9900_0000, 4'b1000);
    cpu_acc(1'b0, 12'h000, 1'b0, '0, 4'hF, 2'd2, rd, w);
    chk("R2 lane3", rd, 32'h9934_CC78);

    // R3 override, including bit 0 set
    set_addr(32'h8000_1234, 4'hF);
    data_acc("R3", 12'h003, 1'b0, '0, 2'd0, 0);
    data_acc("R3", 12'h006, 1'b1, 32'h0000_00EE, 2'd0, 1);
    set_addr(32'h8001_0A05, 4'hF);
    data_acc("R3", 12'h002, 1'b0, '0, 2'd1, 0);

    // R4 type-1
    set_addr(32'h0001_0A05, 4'hF);
    data_acc("R4", 12'h005, 1'b0, '0, 2'd0, 0);
    data_acc("R4", 12'h002, 1'b1, 32'h0000_BEEF, 2'd1, 2);

    // R5/R6 one-hot device select
    set_addr(32'h0000_0850, 4'hF);
    data_acc("R5 dev0", 12'h000, 1'b0, '0, 2'd2, 0);
    set_addr(32'h0210_05A8, 4'hF);
    data_acc("R5 lowest of two", 12'h004, 1'b0, '0, 2'd2, 0);
    set_addr(32'h4000_07F8, 4'hF);
    data_acc("R6 top bit fields", 12'h007, 1'b1, 32'hCAFE_F00D, 2'd2, 0);
    set_addr(32'h7FFF_F300, 4'hF);
    data_acc("R6 all bits", 12'h001, 1'b0, '0, 2'd0, 0);

    // R7 master abort
    set_addr(32'h0000_07F8, 4'hF);
    data_acc("R7", 12'h000, 1'b0, '0, 2'd2, 0);
    data_acc("R7", 12'h004, 1'b1, 32'h1111_2222, 2'd2, 0);

    // R8/R9 sizes and acknowledge delays
    set_addr(32'h0080_0310, 4'hF);
    data_acc("R8 size1", 12'h003, 1'b1, 32'h0000_0042, 2'd0, 3);
    data_acc("R8 size2", 12'h002, 1'b0, '0, 2'd1, 7);
    data_acc("R9 size4", 12'h000, 1'b1, 32'hDEAD_BEEF, 2'd2, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule